// File: doc/BRIEF.md
# NaN Payload Format Converter

This block moves a NaN from one binary floating-point width to another and keeps its sign and its payload. The widths are 32-bit single, 64-bit double and the 80-bit extended format with an explicit integer bit. The source NaN is first unpacked into a canonical form. That form is a sign plus a 64-bit payload word, with the fraction pushed up against the most significant bit. The word is then repacked for the destination. Narrowing drops low payload bits and widening appends zeros, so the quiet bit always lands on the quiet bit.

Two mode inputs shape the result. The default-NaN enable replaces every result with the canonical default NaN of the destination. The polarity input selects which value of the fraction's top bit marks a signaling NaN. A signaling source raises the invalid flag, and the result is made quiet. The conversion is combinational. The result and the flag are captured in one output register, so both appear one clock after the inputs.

Top module: `nan_precision_conv`

## Requirements
- R1: While `rst` is high, the next clock edge clears `dst_val` and `invalid` to zero. Otherwise each edge captures the conversion of the inputs present at that edge, which gives a latency of one clock.
- R2: Format code 0 is single, held in bits [31:0]. Code 1 is double, held in [63:0]. Codes 2 and 3 are both extended: sign and exponent in [79:64], significand in [63:0], integer bit at 63. Output bits above the destination width are zero.
- R3: With `snan_pol` = 0, a NaN is signaling when its quiet bit is clear and the remaining fraction is nonzero. The quiet bit is bit 22 for single, bit 51 for double and bit 62 for extended. With `snan_pol` = 1, a NaN is signaling when that bit is set. `invalid` is 1 exactly when the source is signaling.
- R4: The sign is carried across. The fraction is left-aligned, so narrowing keeps its top bits and widening appends zeros below it.
- R5: An extended source whose integer bit is clear is replaced by the default extended NaN before it is classified and converted. That NaN has sign and exponent 0xFFFF and significand 0xC000000000000000.
- R6: An extended result has exponent 0x7FFF, the sign at bit 79 and the integer bit set. The payload sits directly below the integer bit.
- R7: If the destination fraction would be zero after truncation, the result is the default NaN. For `snan_pol` = 0 the defaults are 0x7FC00000 (single) and 0x7FF8000000000000 (double). For `snan_pol` = 1 they are 0x7FBFFFFF and 0x7FF7FFFFFFFFFFFF. The extended default is always the value in R5.
- R8: With `dnan_en` = 1, every result is the default NaN of the destination format.
- R9: For a signaling source with `snan_pol` = 0, the result has its quiet bit forced to one. For an extended result, 0xC000000000000000 is ORed into the significand. With `snan_pol` = 1 the result is the default NaN.
- R10: With `dnan_en` = 0 and `snan_pol` = 0, a quiet NaN that is widened and then narrowed back comes out bit-exact.
- R11: Every result is a NaN of the destination format: the exponent is all ones, the fraction is nonzero, and for extended the integer bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_val | input | 80 | Source NaN, packed as in R2 |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| dnan_en | input | 1 | Force the default NaN on every result |
| snan_pol | input | 1 | 0: a set top fraction bit means quiet; 1: it means signaling |
| dst_val | output | 80 | Converted NaN, registered |
| invalid | output | 1 | Source was signaling, registered |

## Verification
The properties take the format codes and mode bits sampled at one edge to describe the output seen at the next. They therefore rely on the single register stage and on inputs that are stable around each edge. The bench changes inputs only on the falling edge. The NaN-shape and quieting properties hold for any source word. Only the round-trip expectation assumes a genuine quiet NaN, so the random stimulus forces an all-ones exponent and a nonzero fraction for single and double sources, and builds round-trip cases only from quiet NaNs.

// File: rtl/nanconv_pkg.sv
package nanconv_pkg;

    localparam int VAL_W    = 80;
    localparam int PAY_W    = 64;
    localparam int SGL_W    = 32;
    localparam int SGL_FRAC = 23;
    localparam int DBL_W    = 64;
    localparam int DBL_FRAC = 52;
    localparam int XHI_W    = 16;
    localparam int XLO_W    = 64;
    localparam int SGL_SH   = PAY_W - SGL_FRAC;     // 41
    localparam int DBL_SH   = PAY_W - DBL_FRAC;     // 12
    localparam int XFR_W    = XLO_W - 1;            // 63

    typedef enum logic [1:0] {
        FMT_SGL  = 2'd0,
        FMT_DBL  = 2'd1,
        FMT_EXT  = 2'd2,
        FMT_EXTB = 2'd3
    } fmt_e;

    typedef struct packed {
        logic             sign;
        logic [PAY_W-1:0] pay;
    } canon_t;

    localparam logic [XHI_W-1:0] XDEF_HI  = 16'hFFFF;
    localparam logic [XLO_W-1:0] XDEF_LO  = 64'hC000_0000_0000_0000;
    localparam logic [XLO_W-1:0] XQUIET   = 64'hC000_0000_0000_0000;
    localparam logic [SGL_W-1:0] SGL_QBIT = 32'h0040_0000;
    localparam logic [DBL_W-1:0] DBL_QBIT = 64'h0008_0000_0000_0000;

    function automatic logic fmt_is_ext(logic [1:0] f);
        return f[1];
    endfunction

    function automatic logic [VAL_W-1:0] default_nan(logic [1:0] f, logic pol);
        if (fmt_is_ext(f))
            return {XDEF_HI, XDEF_LO};
        else if (f[0])
            return {16'h0, (pol ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h7FF8_0000_0000_0000)};
        else
            return {48'h0, (pol ? 32'h7FBF_FFFF : 32'h7FC0_0000)};
    endfunction

    function automatic logic sgl_signaling(logic [SGL_W-1:0] v, logic pol);
        logic ones;
        ones = (v[30:23] == 8'hFF);
        if (pol) return ones && v[22];
        return ones && !v[22] && (v[21:0] != '0);
    endfunction

    function automatic logic dbl_signaling(logic [DBL_W-1:0] v, logic pol);
        logic ones;
        ones = (v[62:52] == 11'h7FF);
        if (pol) return ones && v[51];
        return ones && !v[51] && (v[50:0] != '0);
    endfunction

    function automatic logic ext_signaling(logic [XHI_W-2:0] e, logic [XLO_W-1:0] m, logic pol);
        logic ones;
        ones = (e == 15'h7FFF);
        if (pol) return ones && m[62];
        return ones && !m[62] && (m[61:0] != '0);
    endfunction

endpackage

// File: rtl/nan_unpack.sv
module nan_unpack
    import nanconv_pkg::*;
(
    input  logic [VAL_W-1:0] src_val,
    input  logic [1:0]       src_fmt,
    input  logic             snan_pol,
    output canon_t           canon,
    output logic             is_snan
);

    logic [XHI_W-1:0] x_hi;
    logic [XLO_W-1:0] x_lo;

    // Extended operand with integer bit clear is swapped for the default NaN.
    always_comb begin
        x_hi = src_val[VAL_W-1:XLO_W];
        x_lo = src_val[XLO_W-1:0];
        if (!x_lo[XLO_W-1]) begin
            x_hi = XDEF_HI;
            x_lo = XDEF_LO;
        end
    end

    always_comb begin
        canon   = '0;
        is_snan = 1'b0;
        if (fmt_is_ext(src_fmt)) begin
            canon.sign = x_hi[XHI_W-1];
            canon.pay  = {x_lo[XLO_W-2:0], 1'b0};
            is_snan    = ext_signaling(x_hi[XHI_W-2:0], x_lo, snan_pol);
        end else if (src_fmt[0]) begin
            canon.sign = src_val[DBL_W-1];
            canon.pay  = {src_val[DBL_FRAC-1:0], {DBL_SH{1'b0}}};
            is_snan    = dbl_signaling(src_val[DBL_W-1:0], snan_pol);
        end else begin
            canon.sign = src_val[SGL_W-1];
            canon.pay  = {src_val[SGL_FRAC-1:0], {SGL_SH{1'b0}}};
            is_snan    = sgl_signaling(src_val[SGL_W-1:0], snan_pol);
        end
    end

endmodule

// File: rtl/nan_pack.sv
module nan_pack
    import nanconv_pkg::*;
(
    input  canon_t           canon,
    input  logic [1:0]       dst_fmt,
    input  logic             dnan_en,
    input  logic             snan_pol,
    input  logic             is_snan,
    output logic [VAL_W-1:0] dst_val
);

    logic             empty;
    logic             use_dflt;
    logic [VAL_W-1:0] built;

    always_comb begin
        if (fmt_is_ext(dst_fmt)) begin
            empty = ((canon.pay >> 1) == '0);
            built = {canon.sign, 15'h7FFF, 1'b1, XFR_W'(canon.pay >> 1)};
            if (is_snan)
                built[XLO_W-1:0] = built[XLO_W-1:0] | XQUIET;
        end else if (dst_fmt[0]) begin
            empty = ((canon.pay >> DBL_SH) == '0);
            built = {16'h0, canon.sign, 11'h7FF, DBL_FRAC'(canon.pay >> DBL_SH)};
            if (is_snan)
                built[DBL_W-1:0] = built[DBL_W-1:0] | DBL_QBIT;
        end else begin
            empty = ((canon.pay >> SGL_SH) == '0);
            built = {48'h0, canon.sign, 8'hFF, SGL_FRAC'(canon.pay >> SGL_SH)};
            if (is_snan)
                built[SGL_W-1:0] = built[SGL_W-1:0] | SGL_QBIT;
        end
        use_dflt = dnan_en | empty | (is_snan & snan_pol);
        dst_val  = use_dflt ? default_nan(dst_fmt, snan_pol) : built;
    end

endmodule

// File: rtl/nan_precision_conv.sv
module nan_precision_conv
    import nanconv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] src_val,
    input  logic [1:0]       src_fmt,
    input  logic [1:0]       dst_fmt,
    input  logic             dnan_en,
    input  logic             snan_pol,
    output logic [VAL_W-1:0] dst_val,
    output logic             invalid
);

    canon_t           canon;
    logic             snan_c;
    logic [VAL_W-1:0] val_c;

    nan_unpack u_unpack (
        .src_val  (src_val),
        .src_fmt  (src_fmt),
        .snan_pol (snan_pol),
        .canon    (canon),
        .is_snan  (snan_c)
    );

    nan_pack u_pack (
        .canon    (canon),
        .dst_fmt  (dst_fmt),
        .dnan_en  (dnan_en),
        .snan_pol (snan_pol),
        .is_snan  (snan_c),
        .dst_val  (val_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_val <= '0;
            invalid <= 1'b0;
        end else begin
            dst_val <= val_c;
            invalid <= snan_c;
        end
    end

endmodule

// File: rtl/nanconv_chk.sv
module nanconv_chk
    import nanconv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       dst_fmt,
    input logic             dnan_en,
    input logic             snan_pol,
    input logic [VAL_W-1:0] dst_val,
    input logic             invalid
);

    logic seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    function automatic logic shaped_nan(logic [VAL_W-1:0] v, logic [1:0] f);
        if (f[1])
            return (v[78:64] == 15'h7FFF) && v[63] && (v[62:0] != '0);
        else if (f[0])
            return (v[79:64] == '0) && (v[62:52] == 11'h7FF) && (v[51:0] != '0);
        else
            return (v[79:32] == '0) && (v[30:23] == 8'hFF) && (v[22:0] != '0);
    endfunction

    function automatic logic quiet_set(logic [VAL_W-1:0] v, logic [1:0] f);
        if (f[1])      return v[62];
        else if (f[0]) return v[51];
        else           return v[22];
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dst_val == '0 && !invalid));

    // R11
    out_is_nan_chk: assert property (@(posedge clk) disable iff (rst)
        seen |-> shaped_nan(dst_val, $past(dst_fmt)));

    // R8
    dnan_default_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(dnan_en)) |-> (dst_val == default_nan($past(dst_fmt), $past(snan_pol))));

    // R9
    snan_quieted_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && invalid && !$past(snan_pol)) |-> quiet_set(dst_val, $past(dst_fmt)));

    // R9
    snan_pol1_default_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && invalid && $past(snan_pol)) |-> (dst_val == default_nan($past(dst_fmt), 1'b1)));

    // R6
    ext_int_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(dst_fmt[1])) |-> (dst_val[63] && dst_val[78:64] == 15'h7FFF));

endmodule

bind nan_precision_conv nanconv_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .dst_fmt  (dst_fmt),
    .dnan_en  (dnan_en),
    .snan_pol (snan_pol),
    .dst_val  (dst_val),
    .invalid  (invalid)
);

// File: tb/sim_nan_precision_conv.sv
`timescale 1ns/1ps
module sim_nan_precision_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [79:0] src_val = '0;
    logic [1:0]  src_fmt = 2'd0;
    logic [1:0]  dst_fmt = 2'd0;
    logic        dnan_en = 1'b0;
    logic        snan_pol = 1'b0;
    logic [79:0] dst_val;
    logic        invalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nan_precision_conv u0 (
        .clk(clk), .rst(rst), .src_val(src_val), .src_fmt(src_fmt),
        .dst_fmt(dst_fmt), .dnan_en(dnan_en), .snan_pol(snan_pol),
        .dst_val(dst_val), .invalid(invalid)
    );

    // Behavioural reference: {invalid, value}
    function automatic logic [80:0] model(logic [79:0] v, logic [1:0] sf, logic [1:0] df,
                                          logic dn, logic pol);
        logic        sg, sig;
        logic [63:0] p, f, xl;
        logic [15:0] xh;
        logic [79:0] r, dflt;
        if (sf >= 2) begin
            xh = v[79:64]; xl = v[63:0];
            if (xl[63] == 1'b0) begin xh = 16'hFFFF; xl = 64'hC000000000000000; end
            sg = xh[15];
            p  = xl << 1;
            if (pol) sig = (xh[14:0] == 15'h7FFF) && xl[62];
            else     sig = (xh[14:0] == 15'h7FFF) && !xl[62] && ((xl << 2) != 0);
        end else if (sf == 1) begin
            sg = v[63];
            p  = v[63:0] << 12;
            if (pol) sig = (v[62:51] == 12'hFFF);
            else     sig = (v[62:51] == 12'hFFE) && (v[50:0] != 0);
        end else begin
            sg = v[31];
            p  = {32'h0, v[31:0]} << 41;
            if (pol) sig = (v[30:22] == 9'h1FF);
            else     sig = (v[30:22] == 9'h1FE) && (v[21:0] != 0);
        end
        if (df >= 2)      dflt = {16'hFFFF, 64'hC000000000000000};
        else if (df == 1) dflt = pol ? 80'h7FF7FFFFFFFFFFFF : 80'h7FF8000000000000;
        else              dflt = pol ? 80'h7FBFFFFF : 80'h7FC00000;
        if (df >= 2) begin
            f = p >> 1;
            r = {sg, 15'h7FFF, (64'h8000000000000000 | f | (sig ? 64'hC000000000000000 : 64'h0))};
        end else if (df == 1) begin
            f = p >> 12;
            r = {16'h0, sg, 11'h7FF, f[51:0]};
            if (sig) r[51] = 1'b1;
        end else begin
            f = p >> 41;
            r = {48'h0, sg, 8'hFF, f[22:0]};
            if (sig) r[22] = 1'b1;
        end
        if (dn || f == 0 || (sig && pol)) r = dflt;
        return {sig, r};
    endfunction

    task automatic check(input string tag, input logic [79:0] gv, input logic gi,
                         input logic [79:0] ev, input logic ei);
        checks++;
        if (gv !== ev || gi !== ei) begin
            errors++;
            $display("FAIL %s val=%h inv=%b expected val=%h inv=%b", tag, gv, gi, ev, ei);
        end
    endtask

    // Drive at the falling edge, capture at the rising edge, sample at the next fall.
    task automatic apply(input logic [79:0] v, input logic [1:0] sf, input logic [1:0] df,
                         input logic dn, input logic pol, input string tag);
        logic [80:0] e;
        src_val = v; src_fmt = sf; dst_fmt = df; dnan_en = dn; snan_pol = pol;
        @(posedge clk);
        @(negedge clk);
        e = model(v, sf, df, dn, pol);
        check(tag, dst_val, invalid, e[79:0], e[80]);
    endtask

    function automatic logic [79:0] rand_nan(logic [1:0] f);
        logic [79:0] v;
        v = {$urandom, $urandom, $urandom};
        if (f >= 2) begin
            if ($urandom_range(0, 3) != 0) v[78:64] = 15'h7FFF;
            if ($urandom_range(0, 5) == 0) v[63] = 1'b0;
        end else if (f == 1) begin
            v[79:64] = '0; v[62:52] = 11'h7FF;
            if ($urandom_range(0, 3) == 0) v[51:0] = 52'h1 << $urandom_range(0, 51);
            if (v[51:0] == 0) v[0] = 1'b1;
        end else begin
            v[79:32] = '0; v[30:23] = 8'hFF;
            if ($urandom_range(0, 3) == 0) v[22:0] = 23'h1 << $urandom_range(0, 22);
            if (v[22:0] == 0) v[0] = 1'b1;
        end
        return v;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [79:0] mid, q;
        // R1: reset state
        src_val = 80'h7FFF_8123_4567_89AB_CDEF; src_fmt = 2; dst_fmt = 2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", dst_val, invalid, 80'h0, 1'b0);
        rst = 1'b0;

        // R4/R2: single quiet widened to double, literal
        apply(80'h7FC12345, 0, 1, 0, 0, "R4 s->d");
        check("R4 literal s->d", dst_val, invalid, 80'h7FF82468A0000000, 1'b0);
        // R2: upper output bits zero on single result
        apply(80'h7FF8_0000_0000_0000, 1, 0, 0, 0, "R2 d->s");
        check("R2 literal d->s", dst_val, invalid, 80'h7FC00000, 1'b0);
        // R5: extended integer bit clear -> default extended source
        apply({16'h7FFF, 64'h4000_0000_0000_1234}, 2, 0, 0, 0, "R5 x int clear");
        check("R5 literal", dst_val, invalid, 80'hFFC00000, 1'b0);
        // R7/R3: signaling double whose payload truncates to zero
        apply(80'h7FF0_0000_0000_0001, 1, 0, 0, 0, "R7 empty");
        check("R7 literal", dst_val, invalid, 80'h7FC00000, 1'b1);
        // R3/R9: polarity 1 signaling single -> default double
        apply(80'h7FC00001, 0, 1, 0, 1, "R9 pol1");
        check("R9 pol1 literal", dst_val, invalid, 80'h7FF7FFFFFFFFFFFF, 1'b1);
        // R3: polarity 1 quiet single keeps payload
        apply(80'h7F800001, 0, 1, 0, 1, "R3 pol1 quiet");
        check("R3 pol1 literal", dst_val, invalid, 80'h7FF0000020000000, 1'b0);
        // R8: default mode
        apply(80'hFFC12345, 0, 2, 1, 0, "R8 dnan");
        check("R8 literal", dst_val, invalid, {16'hFFFF, 64'hC000000000000000}, 1'b0);
        // R6: single to extended, negative
        apply(80'hFFC00001, 0, 2, 0, 0, "R6 s->x");
        check("R6 literal", dst_val, invalid, {16'hFFFF, 64'hC000010000000000}, 1'b0);
        // R9: signaling single to extended, quieted
        apply(80'h7F800001, 0, 3, 0, 0, "R9 s->x code3");
        check("R9 literal", dst_val, invalid, {16'h7FFF, 64'hC000010000000000}, 1'b1);

        // R10: round trips
        for (int i = 0; i < 200; i++) begin
            q = rand_nan(0); q[22] = 1'b1;
            apply(q, 0, 1, 0, 0, "R10 s->d");
            mid = dst_val;
            apply(mid, 1, 0, 0, 0, "R10 d->s");
            check("R10 roundtrip s-d-s", dst_val, invalid, q, 1'b0);
            apply(q, 0, 2, 0, 0, "R10 s->x");
            mid = dst_val;
            apply(mid, 2, 0, 0, 0, "R10 x->s");
            check("R10 roundtrip s-x-s", dst_val, invalid, q, 1'b0);
            q = rand_nan(1); q[51] = 1'b1;
            apply(q, 1, 2, 0, 0, "R10 d->x");
            mid = dst_val;
            apply(mid, 2, 1, 0, 0, "R10 x->d");
            check("R10 roundtrip d-x-d", dst_val, invalid, q, 1'b0);
        end

        // R3 R4 R7 R8 R9 R11: random sweep against the model
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] sf, df;
            sf = 2'($urandom_range(0, 3));
            df = 2'($urandom_range(0, 3));
            apply(rand_nan(sf), sf, df, ($urandom_range(0, 7) == 0),
                  1'($urandom_range(0, 1)), "R11 random");
        end

        // R1: reset again mid-run
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 reset again", dst_val, invalid, 80'h0, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule